// File: doc/BRIEF.md
# Aggressor Tree Tracker

This block counts row activations in one DRAM bank to spot rows that are hammered hard enough to disturb their neighbours. It keeps a small pool of counters arranged as a binary tree over the 16-bit row address space. The tree begins each refresh interval as one leaf that covers every row. When a leaf's count reaches a split level, it is divided into two leaves, one for the lower half of its range and one for the upper half. Busy regions therefore get narrow counters, while quiet regions share one wide counter.

Each accepted activation walks the tree from the root, one level per cycle, and then updates the leaf it reaches. If that leaf's count reaches the refresh level, the block issues a one-cycle refresh request. The request gives the leaf's row range widened by one row on each side, and the leaf's count returns to zero. A pulse on the interval-end input clears the tree back to a single root. If a lookup is in progress, the clear waits until that lookup has finished.

The controller has four states. IDLE accepts an activation, which leads to WALK, or handles a pending interval end, which leads to CLEAR. WALK descends one level per cycle while the node it reads is internal, and moves to UPDATE when that node is a leaf. UPDATE increments the leaf, refreshes or splits it, and returns to IDLE. CLEAR rebuilds the root leaf, resets the allocator and returns to IDLE.

Top module: `aggr_tree_tracker`

## Requirements
- R1: After reset, `act_ready` is 1, `refresh_valid` is 0, and the tree is a single root leaf with count zero that covers rows 0 to 65535.
- R2: An activation is taken on a rising clock edge where `act_valid` and `act_ready` are both 1. `act_ready` is then 0 for exactly d+2 cycles, where d is the depth of the leaf that holds the row (the root is depth 0).
- R3: Each accepted activation adds one to the count of the single leaf whose range contains `act_row`.
- R4: When an increment brings a leaf's count to REFRESH_TH, `refresh_valid` is 1 for exactly one cycle. That cycle is the first one in which the lookup is finished. The leaf's count is then zero.
- R5: A leaf at depth d covers 2^(16-d) rows. When an increment brings its count exactly to SPLIT_TH, the leaf becomes internal and gets two leaf children, provided d < MAX_DEPTH and at least two counters are still unallocated. Each child holds that count. Rows below the midpoint of the range go to the lower child, and all other rows go to the upper child.
- R6: When fewer than two counters are free, a leaf that reaches SPLIT_TH stays a leaf and keeps counting toward REFRESH_TH.
- R7: A leaf at depth MAX_DEPTH never splits, even when counters are free.
- R8: An `interval_end` pulse drops `act_ready` at once and resets the tree to one root leaf with count zero. If the pulse arrives during a lookup, that lookup finishes first, including any refresh request it produces. The clear adds two cycles of `act_ready` low.
- R9: A refresh request reports `refresh_lo` as the leaf's first row minus one, held at 0, and `refresh_hi` as the leaf's last row plus one, held at 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| act_valid | input | 1 | An activation is offered |
| act_row | input | 16 | Row address of the activation |
| act_ready | output | 1 | An activation can be taken this cycle |
| interval_end | input | 1 | Pulse marking the end of a refresh interval |
| refresh_valid | output | 1 | One-cycle refresh request |
| refresh_lo | output | 16 | First row to refresh |
| refresh_hi | output | 16 | Last row to refresh |

## Verification
The assertions assume that `act_valid` and `act_row` stay in place until the handshake, and that `interval_end` is high for a single cycle at a time. The allocator-step property also assumes that nothing else drives the allocator between interval clears. The bench keeps to these rules by driving every input on the falling clock edge. It holds each activation until `act_ready` is seen and pulses `interval_end` for exactly one cycle. The thresholds, pool size and depth limit are set small, so that splits, pool exhaustion and the depth cap all occur within a few dozen activations.

// File: rtl/att_pkg.sv
package att_pkg;
    localparam int ROW_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WALK,
        ST_UPDATE,
        ST_CLEAR
    } att_state_e;
endpackage

// File: rtl/att_node_store.sv
module att_node_store #(
    parameter int POOL  = 32,
    parameter int CNT_W = 10,
    localparam int IDX_W = $clog2(POOL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_leaf,
    output logic [CNT_W-1:0] rd_cnt,
    output logic [IDX_W-1:0] rd_left,
    output logic [IDX_W-1:0] rd_right,
    input  logic             clr_root,
    input  logic             cnt_we,
    input  logic [IDX_W-1:0] cnt_idx,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             split_we,
    input  logic [IDX_W-1:0] split_idx,
    input  logic [IDX_W-1:0] child_idx,
    input  logic [CNT_W-1:0] child_cnt
);
    logic             leaf_q  [POOL];
    logic [CNT_W-1:0] cnt_q   [POOL];
    logic [IDX_W-1:0] left_q  [POOL];
    logic [IDX_W-1:0] right_q [POOL];

    logic [IDX_W-1:0] child_hi;
    assign child_hi = child_idx + IDX_W'(1);

    for (genvar n = 0; n < POOL; n++) begin : g_node
        localparam logic [IDX_W-1:0] ME = IDX_W'(n);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                leaf_q[n]  <= 1'b1;
                cnt_q[n]   <= '0;
                left_q[n]  <= '0;
                right_q[n] <= '0;
            end else if (clr_root && n == 0) begin
                leaf_q[n] <= 1'b1;
                cnt_q[n]  <= '0;
            end else if (split_we && split_idx == ME) begin
                leaf_q[n]  <= 1'b0;
                left_q[n]  <= child_idx;
                right_q[n] <= child_hi;
            end else if (split_we && (child_idx == ME || child_hi == ME)) begin
                leaf_q[n] <= 1'b1;
                cnt_q[n]  <= child_cnt;
            end else if (cnt_we && cnt_idx == ME) begin
                cnt_q[n] <= cnt_val;
            end
        end
    end

    assign rd_leaf  = leaf_q[rd_idx];
    assign rd_cnt   = cnt_q[rd_idx];
    assign rd_left  = left_q[rd_idx];
    assign rd_right = right_q[rd_idx];
endmodule

// File: rtl/att_alloc.sv
module att_alloc #(
    parameter int POOL = 32,
    localparam int IDX_W = $clog2(POOL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             take_pair,
    output logic [IDX_W-1:0] next_free,
    output logic             pair_avail
);
    logic [IDX_W:0] used_plus2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         next_free <= IDX_W'(1);
        else if (clr)       next_free <= IDX_W'(1);
        else if (take_pair) next_free <= next_free + IDX_W'(2);
    end

    assign used_plus2 = {1'b0, next_free} + (IDX_W + 1)'(2);
    assign pair_avail = used_plus2 <= (IDX_W + 1)'(POOL);
endmodule

// File: rtl/att_span.sv
module att_span #(
    parameter int ROW_W = 16,
    localparam int DEPTH_W = $clog2(ROW_W + 1)
) (
    input  logic [ROW_W-1:0]   row,
    input  logic [ROW_W-1:0]   node_lo,
    input  logic [DEPTH_W-1:0] depth,
    output logic               go_upper,
    output logic [ROW_W-1:0]   child_lo,
    output logic [ROW_W-1:0]   ext_lo,
    output logic [ROW_W-1:0]   ext_hi
);
    localparam logic [ROW_W:0] TOP_ROW = {1'b0, {ROW_W{1'b1}}};

    logic [ROW_W:0] size_w, half_w, lo_w, mid_w, last_w;

    always_comb begin
        size_w   = (ROW_W + 1)'(1) << (ROW_W - int'(depth));
        half_w   = size_w >> 1;
        lo_w     = {1'b0, node_lo};
        mid_w    = lo_w + half_w;
        last_w   = lo_w + size_w - (ROW_W + 1)'(1);
        go_upper = {1'b0, row} >= mid_w;
        child_lo = go_upper ? mid_w[ROW_W-1:0] : node_lo;
        ext_lo   = (node_lo == '0) ? '0 : node_lo - ROW_W'(1);
        ext_hi   = (last_w >= TOP_ROW) ? {ROW_W{1'b1}}
                                       : last_w[ROW_W-1:0] + ROW_W'(1);
    end
endmodule

// File: rtl/aggr_tree_tracker.sv
module aggr_tree_tracker #(
    parameter int POOL       = 32,
    parameter int MAX_DEPTH  = 8,
    parameter int SPLIT_TH   = 256,
    parameter int REFRESH_TH = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        act_valid,
    input  logic [15:0] act_row,
    output logic        act_ready,
    input  logic        interval_end,
    output logic        refresh_valid,
    output logic [15:0] refresh_lo,
    output logic [15:0] refresh_hi
);
    import att_pkg::*;

    localparam int CNT_W   = $clog2(REFRESH_TH);
    localparam int IDX_W   = $clog2(POOL + 1);
    localparam int DEPTH_W = $clog2(ROW_W + 1);

    att_state_e state_q, state_d;

    logic [IDX_W-1:0]   cur_idx;
    logic [ROW_W-1:0]   cur_lo;
    logic [DEPTH_W-1:0] cur_depth;
    logic [ROW_W-1:0]   row_q;
    logic               pend_q;

    logic               rd_leaf;
    logic [CNT_W-1:0]   rd_cnt;
    logic [IDX_W-1:0]   rd_left, rd_right;
    logic [IDX_W-1:0]   next_free;
    logic               pair_avail;

    logic               go_upper;
    logic [ROW_W-1:0]   child_lo, ext_lo, ext_hi;

    logic [CNT_W:0]     inc;
    logic               hit_refresh, do_split;
    logic               take_act, cnt_we, split_we, clr_tree;
    logic [CNT_W-1:0]   cnt_val;

    att_node_store #(.POOL(POOL), .CNT_W(CNT_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (cur_idx),
        .rd_leaf   (rd_leaf),
        .rd_cnt    (rd_cnt),
        .rd_left   (rd_left),
        .rd_right  (rd_right),
        .clr_root  (clr_tree),
        .cnt_we    (cnt_we),
        .cnt_idx   (cur_idx),
        .cnt_val   (cnt_val),
        .split_we  (split_we),
        .split_idx (cur_idx),
        .child_idx (next_free),
        .child_cnt (inc[CNT_W-1:0])
    );

    att_alloc #(.POOL(POOL)) u_alloc (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr_tree),
        .take_pair  (split_we),
        .next_free  (next_free),
        .pair_avail (pair_avail)
    );

    att_span #(.ROW_W(ROW_W)) u_span (
        .row      (row_q),
        .node_lo  (cur_lo),
        .depth    (cur_depth),
        .go_upper (go_upper),
        .child_lo (child_lo),
        .ext_lo   (ext_lo),
        .ext_hi   (ext_hi)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pend_q || interval_end) state_d = ST_CLEAR;
                else if (act_valid)         state_d = ST_WALK;
            end
            ST_WALK:   if (rd_leaf) state_d = ST_UPDATE;
            ST_UPDATE: state_d = ST_IDLE;
            ST_CLEAR:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs and strobes
    always_comb begin
        inc         = {1'b0, rd_cnt} + (CNT_W + 1)'(1);
        hit_refresh = inc >= (CNT_W + 1)'(REFRESH_TH);
        do_split    = !hit_refresh && inc == (CNT_W + 1)'(SPLIT_TH)
                      && pair_avail && cur_depth < DEPTH_W'(MAX_DEPTH);
        cnt_val     = hit_refresh ? '0 : inc[CNT_W-1:0];
        act_ready   = 1'b0;
        cnt_we      = 1'b0;
        split_we    = 1'b0;
        clr_tree    = 1'b0;
        unique case (state_q)
            ST_IDLE:   act_ready = !pend_q && !interval_end;
            ST_WALK:   ;
            ST_UPDATE: begin
                cnt_we   = !do_split;
                split_we = do_split;
            end
            ST_CLEAR:  clr_tree = 1'b1;
            default:   ;
        endcase
        take_act = act_ready && act_valid;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_idx       <= '0;
            cur_lo        <= '0;
            cur_depth     <= '0;
            row_q         <= '0;
            pend_q        <= 1'b0;
            refresh_valid <= 1'b0;
            refresh_lo    <= '0;
            refresh_hi    <= '0;
        end else begin
            refresh_valid <= 1'b0;
            if (state_q == ST_CLEAR) pend_q <= interval_end;
            else if (interval_end)   pend_q <= 1'b1;
            if (take_act) begin
                row_q     <= act_row;
                cur_idx   <= '0;
                cur_lo    <= '0;
                cur_depth <= '0;
            end
            if (state_q == ST_WALK && !rd_leaf) begin
                cur_idx   <= go_upper ? rd_right : rd_left;
                cur_lo    <= child_lo;
                cur_depth <= cur_depth + DEPTH_W'(1);
            end
            if (state_q == ST_UPDATE && hit_refresh) begin
                refresh_valid <= 1'b1;
                refresh_lo    <= ext_lo;
                refresh_hi    <= ext_hi;
            end
        end
    end
endmodule

// File: rtl/aggr_tree_tracker_chk.sv
module aggr_tree_tracker_chk #(
    parameter int POOL = 32,
    localparam int IDX_W = $clog2(POOL + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 act_valid,
    input logic                 act_ready,
    input logic                 interval_end,
    input logic                 refresh_valid,
    input logic [15:0]          refresh_lo,
    input logic [15:0]          refresh_hi,
    input logic [IDX_W-1:0]     next_free,
    input att_pkg::att_state_e  state_q
);
    // R2: a taken activation makes the block busy on the next cycle
    a_r2_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && act_ready) |=> !act_ready);

    // R4: a refresh request lasts one cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_valid |=> !refresh_valid);

    // R9: a widened range always spans more than one row
    a_r9_span_order: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_valid |-> refresh_lo < refresh_hi);

    // R8: an interval end stops new activations on the next cycle
    a_r8_end_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        interval_end |=> !act_ready);

    // R8: a clear leaves only the root allocated
    a_r8_clear_root: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == att_pkg::ST_CLEAR) |=> next_free == IDX_W'(1));

    // R5: the allocator never passes the pool size
    a_r5_pool_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (next_free >= IDX_W'(1)) && ({1'b0, next_free} <= (IDX_W + 1)'(POOL)));

    // R5: outside a clear, counters are only taken two at a time
    a_r5_pair_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != att_pkg::ST_CLEAR) |=>
        (next_free == $past(next_free) || next_free == $past(next_free) + IDX_W'(2)));
endmodule

bind aggr_tree_tracker aggr_tree_tracker_chk #(.POOL(POOL)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .act_valid     (act_valid),
    .act_ready     (act_ready),
    .interval_end  (interval_end),
    .refresh_valid (refresh_valid),
    .refresh_lo    (refresh_lo),
    .refresh_hi    (refresh_hi),
    .next_free     (next_free),
    .state_q       (state_q)
);

// File: tb/aggr_tree_tracker_test.sv
module aggr_tree_tracker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        act_valid = 1'b0;
    logic [15:0] act_row = '0;
    logic        interval_end = 1'b0;
    logic        act_ready, refresh_valid;
    logic [15:0] refresh_lo, refresh_hi;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    aggr_tree_tracker #(.POOL(9), .MAX_DEPTH(3), .SPLIT_TH(3), .REFRESH_TH(5)) uut (
        .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_row(act_row),
        .act_ready(act_ready), .interval_end(interval_end),
        .refresh_valid(refresh_valid), .refresh_lo(refresh_lo), .refresh_hi(refresh_hi)
    );

    typedef struct packed {
        logic [15:0] row;
        logic [7:0]  busy;
        logic        rf;
        logic [15:0] lo;
        logic [15:0] hi;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 35;
    localparam vec_t VEC [NV] = '{
        '{16'h1234, 8'd2, 1'b0, 16'h0000, 16'h0000, 8'd3}, // R3 root count 1
        '{16'h1234, 8'd2, 1'b0, 16'h0000, 16'h0000, 8'd3}, // R3 root count 2
        '{16'hF000, 8'd2, 1'b0, 16'h0000, 16'h0000, 8'd5}, // R5 root splits
        '{16'h1234, 8'd3, 1'b0, 16'h0000, 16'h0000, 8'd2}, // R2 depth 1 busy
        '{16'h1234, 8'd3, 1'b1, 16'h0000, 16'h8000, 8'd9}, // R9 low clamp
        '{16'hF000, 8'd3, 1'b0, 16'h0000, 16'h0000, 8'd5}, // R5 upper half
        '{16'hFFFF, 8'd3, 1'b1, 16'h7FFF, 16'hFFFF, 8'd9}, // R9 high clamp
        '{16'h0001, 8'd3, 1'b0, 16'h0000, 16'h0000, 8'd4}, // R4 count zeroed
        '{16'h0001, 8'd3, 1'b0, 16'h0000, 16'h0000, 8'd4},
        '{16'h0001, 8'd3, 1'b0, 16'h0000, 16'h0000, 8'd5}, // R5 node splits
        '{16'h4000, 8'd4, 1'b0, 16'h0000, 16'h0000, 8'd5}, // R5 midpoint to upper
        '{16'h4000, 8'd4, 1'b1, 16'h3FFF, 16'h8000, 8'd4}, // R4 refresh
        '{16'h0001, 8'd4, 1'b0, 16'h0000, 16'h0000, 8'd3},
        '{16'h3FFF, 8'd4, 1'b1, 16'h0000, 16'h4000, 8'd5}, // R5 below midpoint
        '{16'h2000, 8'd4, 1'b0, 16'h0000, 16'h0000, 8'd3},
        '{16'h2000, 8'd4, 1'b0, 16'h0000, 16'h0000, 8'd3},
        '{16'h2000, 8'd4, 1'b0, 16'h0000, 16'h0000, 8'd5}, // R5 depth 2 split
        '{16'h2000, 8'd5, 1'b0, 16'h0000, 16'h0000, 8'd2},
        '{16'h2000, 8'd5, 1'b1, 16'h1FFF, 16'h4000, 8'd4},
        '{16'h2100, 8'd5, 1'b0, 16'h0000, 16'h0000, 8'd7},
        '{16'h2100, 8'd5, 1'b0, 16'h0000, 16'h0000, 8'd7},
        '{16'h2100, 8'd5, 1'b0, 16'h0000, 16'h0000, 8'd7}, // R7 at cap
        '{16'h2100, 8'd5, 1'b0, 16'h0000, 16'h0000, 8'd7}, // R7 no split
        '{16'h3FFF, 8'd5, 1'b1, 16'h1FFF, 16'h4000, 8'd7},
        '{16'h9000, 8'd3, 1'b0, 16'h0000, 16'h0000, 8'd5},
        '{16'h9000, 8'd3, 1'b0, 16'h0000, 16'h0000, 8'd5},
        '{16'h9000, 8'd3, 1'b0, 16'h0000, 16'h0000, 8'd5}, // R5 last pair
        '{16'hC000, 8'd4, 1'b0, 16'h0000, 16'h0000, 8'd5},
        '{16'h8000, 8'd4, 1'b0, 16'h0000, 16'h0000, 8'd3},
        '{16'h8000, 8'd4, 1'b1, 16'h7FFF, 16'hC000, 8'd4},
        '{16'h8000, 8'd4, 1'b0, 16'h0000, 16'h0000, 8'd6},
        '{16'h8000, 8'd4, 1'b0, 16'h0000, 16'h0000, 8'd6},
        '{16'h8000, 8'd4, 1'b0, 16'h0000, 16'h0000, 8'd6}, // R6 pool empty
        '{16'h8000, 8'd4, 1'b0, 16'h0000, 16'h0000, 8'd6}, // R6 no split
        '{16'hBFFF, 8'd4, 1'b1, 16'h7FFF, 16'hC000, 8'd6}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic activate(input logic [15:0] row, input bit end_mid,
                            output int busy, output bit rf,
                            output logic [15:0] lo, output logic [15:0] hi);
        busy = 0; rf = 0; lo = '0; hi = '0;
        @(negedge clk);
        while (!act_ready) @(negedge clk);
        act_valid = 1'b1;
        act_row   = row;
        @(negedge clk);
        act_valid = 1'b0;
        if (end_mid) interval_end = 1'b1;
        forever begin
            if (refresh_valid) begin rf = 1; lo = refresh_lo; hi = refresh_hi; end
            if (act_ready) break;
            busy++;
            @(negedge clk);
            interval_end = 1'b0;
        end
    endtask

    task automatic end_pulse();
        @(negedge clk);
        interval_end = 1'b1;
        #1 check("R8 ready gated by pulse", int'(act_ready), 0);
        @(negedge clk);
        interval_end = 1'b0;
        check("R8 busy during clear", int'(act_ready), 0);
        @(negedge clk);
        check("R8 ready after clear", int'(act_ready), 1);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog R2 actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int b; bit f; logic [15:0] l, h;
        repeat (3) @(negedge clk);
        check("R1 ready after reset", int'(act_ready), 1);
        check("R1 no refresh after reset", int'(refresh_valid), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string t;
            activate(VEC[i].row, 1'b0, b, f, l, h);
            t = $sformatf("R%0d vec %0d busy", VEC[i].req, i);
            check(t, b, int'(VEC[i].busy));
            t = $sformatf("R%0d vec %0d refresh", VEC[i].req, i);
            check(t, int'(f), int'(VEC[i].rf));
            if (VEC[i].rf) begin
                t = $sformatf("R%0d vec %0d lo", VEC[i].req, i);
                check(t, int'(l), int'(VEC[i].lo));
                t = $sformatf("R%0d vec %0d hi", VEC[i].req, i);
                check(t, int'(h), int'(VEC[i].hi));
            end
        end

        // R8: clear while idle restores a single root
        end_pulse();
        activate(16'h8000, 1'b0, b, f, l, h);
        check("R8 root after clear", b, 2);
        activate(16'h8000, 1'b0, b, f, l, h);
        end_pulse();
        // counts were zeroed: the split happens on the third hit, not the first
        activate(16'h8000, 1'b0, b, f, l, h);
        check("R8 count cleared a", b, 2);
        activate(16'h8000, 1'b0, b, f, l, h);
        check("R8 count cleared b", b, 2);
        activate(16'h8000, 1'b0, b, f, l, h);
        check("R5 split after clear", b, 2);
        activate(16'h8000, 1'b0, b, f, l, h);
        check("R5 depth 1 after split", b, 3);

        // R8: clear arriving mid-lookup waits and keeps the lookup's refresh
        activate(16'h8000, 1'b1, b, f, l, h);
        check("R8 deferred clear busy", b, 5);
        check("R8 lookup refresh kept", int'(f), 1);
        check("R8 lookup refresh lo", int'(l), 16'h7FFF);
        check("R8 lookup refresh hi", int'(h), 16'hFFFF);
        activate(16'h8000, 1'b0, b, f, l, h);
        check("R8 root after deferred clear", b, 2);

        // R1: reset in mid run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 ready in reset", int'(act_ready), 1);
        check("R1 no refresh in reset", int'(refresh_valid), 0);
        rst_n = 1'b1;
        activate(16'h0042, 1'b0, b, f, l, h);
        check("R1 single root after reset", b, 2);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule